// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Warning and Reset Request

This peripheral watches for a stalled processor. Once enabled, it counts clock ticks. Two thresholds are compared against the count. The first is a warning threshold: when the count reaches it, a level warning output rises so that software can be interrupted before anything drastic happens. The second is a reset threshold: when the count reaches it, the block emits a one-cycle request to the system reset controller. After that request the count freezes until software restarts it.

Software reaches the block through a small word-addressed register bus. The bus has an address, a write strobe, write data and combinational read data. Software keeps the timer quiet by periodically writing a restart command, which returns the count to zero. Software can stop and resume counting through an enable register. A sticky flag records that a timer-requested reset happened. That flag sits in the power-on reset domain, so it survives the system reset that the block itself requested. Early boot code reads the flag to tell a watchdog reset apart from a normal start.

Top module: `wdog_core`

## Requirements
- R1: While `rst_n` is low, and after it is released, the enable, warning threshold and reset threshold registers are zero, `warn_o` and `rst_req_o` are low, and every readable offset returns zero (the status offset also returns zero after `por_n`).
- R2: A write to byte offset 0x04 with data bit 0 = 1 returns the count to zero, clears the frozen state and drops `warn_o` at that write's clock edge. The same write with bit 0 = 0 has no effect. Offset 0x04 always reads zero.
- R3: Offset 0x08 bit 0 is the enable and reads back. Writing 0 stops counting, drops `warn_o` and prevents any reset request. Writing 1 resumes counting from the held count, not from zero.
- R4: With the write that enables counting taking effect at edge E, and a warning threshold B not above the reset threshold, `warn_o` is high after edge E+B+1 and stays high until a restart or a disable. If B is above the reset threshold, `warn_o` never rises, because the count freezes first.
- R5: With reset threshold N, `rst_req_o` is high for exactly the one cycle after edge E+N+1. No further request follows until a restart.
- R6: The warning threshold (offset 0x10) and the reset threshold (offset 0x14) are independent. Each is CNT_W = 29 bits wide. Each reads back its stored value, and write data above bit 28 is dropped and reads as zero.
- R7: Offset 0x0C bit 0 is set one edge after a reset request. It is unaffected by `rst_n`. It is cleared only by `por_n` or by writing 1 to bit 0. Writing 0 leaves it unchanged.
- R8: A threshold of zero fires at the first edge after enabling. With both thresholds at zero, `warn_o` and `rst_req_o` both rise after edge E+1.
- R9: Writes to any offset other than 0x04, 0x08, 0x0C, 0x10 and 0x14, misaligned ones included, change nothing. Reads of such offsets return zero.
- R10: The sequence disable, restart, write warning threshold, write reset threshold, enable is accepted at any time, including after a reset request while the count is frozen. Timing then follows R4 and R5 for the new values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; thresholds are counted in its ticks |
| por_n | input | 1 | Active-low power-on reset; the only reset of the status flag |
| rst_n | input | 1 | Active-low system reset; resets registers and counter |
| bus_addr | input | ADDR_W (8) | Byte offset of the register accessed |
| bus_wr_en | input | 1 | Write strobe, one write per cycle |
| bus_wr_data | input | DATA_W (32) | Write data |
| bus_rd_data | output | DATA_W (32) | Combinational read data for `bus_addr` |
| warn_o | output | 1 | Level warning, high once the count reaches the warning threshold |
| rst_req_o | output | 1 | One-cycle system reset request when the count reaches the reset threshold |

## Verification
Every cycle, assertions check the following:
- the reset request lasts a single cycle;
- a restart leaves the count at zero with both outputs low;
- a frozen count stays still;
- a disabled timer never requests a reset;
- threshold writes land as written and unmapped writes leave the registers alone;
- the status flag is set by a request and otherwise changes only on a clear.

The exact edge at which each output rises depends on the thresholds, on restarts and on pauses. Only the bench scenarios can show that timing. The same holds for survival of the status flag across a system reset and for the warning that never rises when the reset threshold is the lower of the two.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;

    // Byte offsets; software depends on these positions.
    localparam int unsigned OFS_KICK  = 32'h04;
    localparam int unsigned OFS_EN    = 32'h08;
    localparam int unsigned OFS_STAT  = 32'h0C;
    localparam int unsigned OFS_WARN  = 32'h10;
    localparam int unsigned OFS_LIMIT = 32'h14;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_KICK,
        SEL_EN,
        SEL_STAT,
        SEL_WARN,
        SEL_LIMIT
    } reg_sel_e;

endpackage

// File: rtl/wdog_regs.sv
`timescale 1ns/1ps
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              status_i,
    output logic [DATA_W-1:0] rd_data,
    output logic              en_o,
    output logic [CNT_W-1:0]  warn_thr_o,
    output logic [CNT_W-1:0]  limit_thr_o,
    output logic              kick_o,
    output logic              stat_clr_o
);

    localparam int PAD_W = DATA_W - CNT_W;
    localparam logic [ADDR_W-1:0] A_KICK  = ADDR_W'(OFS_KICK);
    localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'(OFS_EN);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_WARN  = ADDR_W'(OFS_WARN);
    localparam logic [ADDR_W-1:0] A_LIMIT = ADDR_W'(OFS_LIMIT);

    typedef struct packed {
        logic             en;
        logic [CNT_W-1:0] warn;
        logic [CNT_W-1:0] limit;
    } regs_t;

    regs_t    r_d, r_q;
    reg_sel_e sel;
    logic     unused_hi;

    assign unused_hi = ^wr_data[DATA_W-1:CNT_W];

    always_comb begin
        case (addr)
            A_KICK:  sel = SEL_KICK;
            A_EN:    sel = SEL_EN;
            A_STAT:  sel = SEL_STAT;
            A_WARN:  sel = SEL_WARN;
            A_LIMIT: sel = SEL_LIMIT;
            default: sel = SEL_NONE;
        endcase
    end

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (sel)
                SEL_EN:    r_d.en    = wr_data[0];
                SEL_WARN:  r_d.warn  = wr_data[CNT_W-1:0];
                SEL_LIMIT: r_d.limit = wr_data[CNT_W-1:0];
                default:   r_d = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (sel)
            SEL_EN:    rd_data = {{(DATA_W-1){1'b0}}, r_q.en};
            SEL_STAT:  rd_data = {{(DATA_W-1){1'b0}}, status_i};
            SEL_WARN:  rd_data = {{PAD_W{1'b0}}, r_q.warn};
            SEL_LIMIT: rd_data = {{PAD_W{1'b0}}, r_q.limit};
            default:   rd_data = '0;
        endcase
    end

    assign en_o        = r_q.en;
    assign warn_thr_o  = r_q.warn;
    assign limit_thr_o = r_q.limit;
    assign kick_o      = wr_en && (sel == SEL_KICK) && wr_data[0];
    assign stat_clr_o  = wr_en && (sel == SEL_STAT) && wr_data[0];

    AST_WARN_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_WARN) |=> warn_thr_o == $past(wr_data[CNT_W-1:0])); // R6
    AST_LIMIT_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_LIMIT) |=> limit_thr_o == $past(wr_data[CNT_W-1:0])); // R6
    AST_UNMAPPED_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_NONE) |=> ($stable(en_o) && $stable(warn_thr_o) && $stable(limit_thr_o))); // R9

endmodule

// File: rtl/wdog_counter.sv
`timescale 1ns/1ps
module wdog_counter #(
    parameter int CNT_W = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             kick_i,
    input  logic [CNT_W-1:0] warn_thr_i,
    input  logic [CNT_W-1:0] limit_thr_i,
    output logic             warn_o,
    output logic             rst_req_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             held;
        logic             warn;
        logic             req;
    } cnt_state_t;

    cnt_state_t s_d, s_q;
    logic       fire;

    always_comb begin
        s_d     = s_q;
        fire    = en_i && !s_q.held && !kick_i && (s_q.cnt >= limit_thr_i);
        s_d.req = fire;
        if (kick_i) begin
            s_d.cnt  = '0;
            s_d.held = 1'b0;
            s_d.warn = 1'b0;
        end else begin
            if (fire) begin
                s_d.held = 1'b1;
            end else if (en_i && !s_q.held) begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
            if (!en_i) begin
                s_d.warn = 1'b0;
            end else if (s_q.cnt >= warn_thr_i) begin
                s_d.warn = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign warn_o    = s_q.warn;
    assign rst_req_o = s_q.req;

    AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o); // R5
    AST_KICK_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        kick_i |=> (s_q.cnt == '0 && !warn_o && !rst_req_o)); // R2
    AST_FROZEN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.held && !kick_i) |=> $stable(s_q.cnt)); // R5
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !rst_req_o); // R3

endmodule

// File: rtl/wdog_status.sv
`timescale 1ns/1ps
module wdog_status (
    input  logic clk,
    input  logic por_n,
    input  logic req_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (req_i) begin
            flag_d = 1'b1;
        end else if (clr_i) begin
            flag_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag_o = flag_q;

    AST_FLAG_SET_ON_REQ: assert property (@(posedge clk) disable iff (!por_n)
        req_i |=> flag_o); // R7
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
        (!req_i && !clr_i) |=> $stable(flag_o)); // R7

endmodule

// File: rtl/wdog_core.sv
`timescale 1ns/1ps
module wdog_core #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 29
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [DATA_W-1:0] bus_wr_data,
    output logic [DATA_W-1:0] bus_rd_data,
    output logic              warn_o,
    output logic              rst_req_o
);

    logic             en;
    logic             kick;
    logic             stat_clr;
    logic             flag;
    logic [CNT_W-1:0] warn_thr;
    logic [CNT_W-1:0] limit_thr;

    wdog_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr        (bus_addr),
        .wr_en       (bus_wr_en),
        .wr_data     (bus_wr_data),
        .status_i    (flag),
        .rd_data     (bus_rd_data),
        .en_o        (en),
        .warn_thr_o  (warn_thr),
        .limit_thr_o (limit_thr),
        .kick_o      (kick),
        .stat_clr_o  (stat_clr)
    );

    wdog_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en),
        .kick_i      (kick),
        .warn_thr_i  (warn_thr),
        .limit_thr_i (limit_thr),
        .warn_o      (warn_o),
        .rst_req_o   (rst_req_o)
    );

    wdog_status u_status (
        .clk    (clk),
        .por_n  (por_n),
        .req_i  (rst_req_o),
        .clr_i  (stat_clr),
        .flag_o (flag)
    );

endmodule

// File: tb/wdog_core_bench.sv
`timescale 1ns/1ps
module wdog_core_bench;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 29;
    localparam int NVEC   = 6;
    // columns: warning threshold, reset threshold, expected warn edge, expected request edge (-1 = never)
    localparam int VEC [NVEC][4] = '{
        '{3, 5, 4, 6},
        '{5, 3, -1, 4},
        '{0, 0, 1, 1},
        '{2, 2, 3, 3},
        '{7, 10, 8, 11},
        '{1, 0, -1, 1}
    };

    logic              clk = 1'b0;
    logic              por_n = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr_en = 1'b0;
    logic [DATA_W-1:0] bus_wr_data = '0;
    logic [DATA_W-1:0] bus_rd_data;
    logic              warn_o;
    logic              rst_req_o;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;

    wdog_core #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_wdog_core (
        .clk         (clk),
        .por_n       (por_n),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr_en   (bus_wr_en),
        .bus_wr_data (bus_wr_data),
        .bus_rd_data (bus_rd_data),
        .warn_o      (warn_o),
        .rst_req_o   (rst_req_o)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_wr_data = d;
        bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rd_data;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
        logic [31:0] d;
        rd(a, d);
        chk(d == exp, req, int'(d), int'(exp));
    endtask

    // disable, restart, thresholds, enable; returns the enable edge
    task automatic prog(input int b, input int n, output int ref_edge);
        wr(8'h08, 32'd0);
        wr(8'h04, 32'd1);
        wr(8'h10, 32'(b));
        wr(8'h14, 32'(n));
        wr(8'h08, 32'd1);
        ref_edge = cyc;
    endtask

    task automatic watch(input int ref_edge, input int span, output int warn_at,
                         output int req_at, output int nreq, output bit dropped);
        warn_at = -1;
        req_at = -1;
        nreq = 0;
        dropped = 1'b0;
        while (cyc - ref_edge < span) begin
            @(negedge clk);
            if (warn_o && warn_at < 0) warn_at = cyc - ref_edge;
            if (!warn_o && warn_at >= 0) dropped = 1'b1;
            if (rst_req_o) begin
                nreq++;
                if (req_at < 0) req_at = cyc - ref_edge;
            end
        end
    endtask

    initial begin
        #(200000 * 5);
        nfail++;
        $display("FAIL watchdog timeout actual=%0d expected=0", cyc);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

    initial begin
        int r, w, q, nq, e, c;
        bit dr;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk(warn_o == 1'b0, "R1 warn", int'(warn_o), 0);
        chk(rst_req_o == 1'b0, "R1 req", int'(rst_req_o), 0);
        rd_chk(8'h04, 0, "R1 kick read");
        rd_chk(8'h08, 0, "R1 enable");
        rd_chk(8'h0C, 0, "R1 status");
        rd_chk(8'h10, 0, "R1 warn thr");
        rd_chk(8'h14, 0, "R1 limit thr");

        // R6 threshold width and independence
        wr(8'h10, 32'hFFFF_FFFF);
        rd_chk(8'h10, 32'h1FFF_FFFF, "R6 warn width");
        wr(8'h14, 32'h0001_2345);
        rd_chk(8'h14, 32'h0001_2345, "R6 limit readback");
        rd_chk(8'h10, 32'h1FFF_FFFF, "R6 warn untouched");

        // R9 unmapped and misaligned writes
        wr(8'h18, 32'd1);
        wr(8'h00, 32'd5);
        wr(8'h12, 32'd7);
        wr(8'h09, 32'd1);
        rd_chk(8'h10, 32'h1FFF_FFFF, "R9 warn kept");
        rd_chk(8'h14, 32'h0001_2345, "R9 limit kept");
        rd_chk(8'h08, 0, "R9 enable kept");
        rd_chk(8'h18, 0, "R9 unmapped read");
        rd_chk(8'h04, 0, "R2 kick reads zero");

        // R4 R5 R8 R10 table walk
        for (int i = 0; i < NVEC; i++) begin
            prog(VEC[i][0], VEC[i][1], r);
            watch(r, 25, w, q, nq, dr);
            chk(w == VEC[i][2], "R4 warn edge", w, VEC[i][2]);
            chk(q == VEC[i][3], "R5 request edge", q, VEC[i][3]);
            chk(nq == 1, "R5 single request", nq, 1);
            chk(dr == 1'b0, "R4 warn held", int'(dr), 0);
            rd_chk(8'h0C, 1, "R7 status set");
            wr(8'h0C, 32'd1);
            rd_chk(8'h0C, 0, "R7 status cleared");
        end

        // R2 restart with bit 0 clear is ignored
        prog(6, 10, r);
        wr(8'h04, 32'd0);
        watch(r, 20, w, q, nq, dr);
        chk(q == 11, "R2 kick bit0=0 ignored", q, 11);

        // R2 restart with bit 0 set
        prog(4, 9, r);
        watch(r, 6, w, q, nq, dr);
        chk(warn_o == 1'b1, "R4 warn before kick", int'(warn_o), 1);
        wr(8'h04, 32'd1);
        e = cyc;
        chk(warn_o == 1'b0, "R2 kick drops warn", int'(warn_o), 0);
        watch(e, 20, w, q, nq, dr);
        chk(w == 5, "R2 warn after kick", w, 5);
        chk(q == 10, "R2 request after kick", q, 10);

        // R3 pause and resume
        prog(3, 20, r);
        watch(r, 6, w, q, nq, dr);
        wr(8'h08, 32'd0);
        e = cyc;
        c = e - r;
        watch(e, 12, w, q, nq, dr);
        chk(nq == 0, "R3 no request while disabled", nq, 0);
        chk(warn_o == 1'b0, "R3 warn low while disabled", int'(warn_o), 0);
        rd_chk(8'h08, 0, "R3 enable reads 0");
        wr(8'h08, 32'd1);
        e = cyc;
        watch(e, 30, w, q, nq, dr);
        chk(q == 20 - c + 1, "R3 resume from held count", q, 20 - c + 1);
        chk(warn_o == 1'b1, "R3 warn after resume", int'(warn_o), 1);

        // R7 status survives system reset
        rd_chk(8'h0C, 1, "R7 set before reset");
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd_chk(8'h0C, 1, "R7 survives rst_n");
        rd_chk(8'h14, 0, "R1 limit cleared by rst_n");
        rd_chk(8'h08, 0, "R1 enable cleared by rst_n");
        wr(8'h0C, 32'd0);
        rd_chk(8'h0C, 1, "R7 write 0 keeps");
        wr(8'h0C, 32'd1);
        rd_chk(8'h0C, 0, "R7 write 1 clears");

        // R7 power-on reset clears the flag
        prog(0, 0, r);
        watch(r, 4, w, q, nq, dr);
        rd_chk(8'h0C, 1, "R7 set again");
        @(negedge clk);
        por_n = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
        rst_n = 1'b1;
        rd_chk(8'h0C, 0, "R7 por clears");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

endmodule